// File: doc/BRIEF.md
# Addressed Peripheral Read Port

This block sits between one peripheral register and a read bus shared by up to sixteen peripherals. Each peripheral is given its identity on a 4-bit address input. The bus master reads by putting an address on the bus and raising its read strobe. While no read is aimed at it, the block tracks the peripheral's register value every cycle in a local snapshot register and keeps its bus driver off.

When the bus address equals the block's own address and the read strobe is high at a clock edge, the block freezes the snapshot and enables its driver. From the next cycle it presents the frozen value on the bus. It keeps driving that value, whatever the address or the register does, until the strobe is seen low, and then it releases the bus. The output is a data word plus a drive enable, so a tri-state pad or a wired-OR bus can be built outside. While the drive enable is low the data word is held at zero.

The read strobe is a plain level handshake, not valid/ready. The master controls how long a read lasts by holding the strobe, and the block applies no back-pressure.

Top module: `periph_read_port`

## Requirements
- R1: A synchronous active-high reset, which takes priority over every other input, leaves `bus_drive` at 0 and `bus_data` at 0 after the clock edge.
- R2: While the block is idle, `bus_drive` is 0 and `bus_data` is 0.
- R3: The block starts driving only when, at a clock edge, `bus_addr` equals `my_addr` and `rd_req` is 1. `bus_drive` is 1 in the cycle after that edge.
- R4: With `rd_req` at 1 and `bus_addr` not equal to `my_addr`, an idle block stays idle.
- R5: With `bus_addr` equal to `my_addr` and `rd_req` at 0, an idle block stays idle.
- R6: The first driven `bus_data` equals the `reg_val` present at the clock edge where the match was seen.
- R7: While `bus_drive` is 1, changes on `reg_val` do not reach `bus_data`, and `bus_data` holds its value.
- R8: Once driving, the block keeps `bus_drive` at 1 for as long as `rd_req` stays 1, even if `bus_addr` changes.
- R9: A clock edge with `rd_req` at 0 while driving releases the bus, so `bus_drive` is 0 in the next cycle.
- R10: After a release, the next read returns the value of `reg_val` at its own match edge, not the earlier snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | input | 1 | Master read strobe |
| bus_addr | input | ADDR_W (4) | Address driven by the master |
| my_addr | input | ADDR_W (4) | This peripheral's own address |
| reg_val | input | DATA_W (32) | Live value of the peripheral register |
| bus_data | output | DATA_W (32) | Frozen snapshot while driving, zero otherwise |
| bus_drive | output | 1 | Bus driver enable |

## Verification
The assertions check several rules on every cycle. Driving starts only after a match edge with the strobe high and continues while the strobe stays high. A low strobe ends driving one cycle later. The snapshot and the bus word stay stable throughout a transfer, and the first driven word equals the register value from the match cycle. Some behaviour is shown only by the bench's scenarios. These are the exact values read across several back-to-back transfers, the snapshot being refreshed between reads, reset winning over a match that arrives in the same cycle, and the address extremes with a changed own address.

// File: rtl/periph_read_pkg.sv
package periph_read_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } rd_state_e;
endpackage

// File: rtl/addr_match.sv
module addr_match #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);
  assign eq = (a == b);
endmodule

// File: rtl/snap_reg.sv
module snap_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/read_ctrl.sv
module read_ctrl
  import periph_read_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_req,
  input  logic hit,
  output logic drive,
  output logic load
);
  rd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (hit && rd_req) state_d = ST_SEND;
      ST_SEND: if (!rd_req)       state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign drive = (state_q == ST_SEND);
  assign load  = (state_q == ST_IDLE);

  // R3
  start_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    (!drive && hit && rd_req) |=> drive);
  // R4
  no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!drive && !(hit && rd_req)) |=> !drive);
  // R8
  hold_while_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (drive && rd_req) |=> drive);
  // R9
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (drive && !rd_req) |=> !drive);
endmodule

// File: rtl/periph_read_port.sv
module periph_read_port #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] my_addr,
  input  logic [DATA_W-1:0] reg_val,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_drive
);
  logic              hit;
  logic              snap_ld;
  logic [DATA_W-1:0] snap_q;

  addr_match #(.W(ADDR_W)) match_i (
    .a  (bus_addr),
    .b  (my_addr),
    .eq (hit)
  );

  read_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .rd_req (rd_req),
    .hit    (hit),
    .drive  (bus_drive),
    .load   (snap_ld)
  );

  snap_reg #(.W(DATA_W)) snap_i (
    .clk  (clk),
    .rst  (rst),
    .load (snap_ld),
    .d    (reg_val),
    .q    (snap_q)
  );

  assign bus_data = bus_drive ? snap_q : '0;

  // R1
  reset_release_chk: assert property (@(posedge clk)
    $past(rst) |-> (!bus_drive && bus_data == '0));
  // R6
  first_word_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_drive) |-> (bus_data == $past(reg_val)));
  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_drive && $past(bus_drive)) |-> $stable(bus_data));
endmodule

// File: tb/periph_read_port_tb_top.sv
module periph_read_port_tb_top;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NV = 14;
  // {rst, rd, addr, val, exp_drive, exp_data}
  localparam int VW = 2 + AW + DW + 1 + DW;

  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'h0, 32'h0000_0011, 1'b0, 32'h0},           // R1 reset
    {1'b0, 1'b0, 4'h5, 32'h0000_0022, 1'b0, 32'h0},           // R5 match, no rd
    {1'b0, 1'b1, 4'h3, 32'h0000_0033, 1'b0, 32'h0},           // R4 rd, wrong addr
    {1'b0, 1'b1, 4'h5, 32'h0000_0044, 1'b1, 32'h0000_0044},   // R3 R6
    {1'b0, 1'b1, 4'h5, 32'h0000_0055, 1'b1, 32'h0000_0044},   // R7
    {1'b0, 1'b1, 4'h9, 32'h0000_0066, 1'b1, 32'h0000_0044},   // R8
    {1'b0, 1'b0, 4'h5, 32'h0000_0077, 1'b0, 32'h0},           // R9
    {1'b0, 1'b0, 4'h5, 32'h0000_0088, 1'b0, 32'h0},           // R2
    {1'b0, 1'b1, 4'h5, 32'h0000_0099, 1'b1, 32'h0000_0099},   // R10
    {1'b0, 1'b1, 4'hF, 32'h0000_00AA, 1'b1, 32'h0000_0099},   // R8
    {1'b0, 1'b0, 4'h0, 32'h0000_00BB, 1'b0, 32'h0},           // R9
    {1'b1, 1'b1, 4'h5, 32'h0000_00CC, 1'b0, 32'h0},           // R1 reset beats match
    {1'b0, 1'b1, 4'h5, 32'h0000_00DD, 1'b1, 32'h0000_00DD},   // R3
    {1'b1, 1'b1, 4'h5, 32'h0000_00EE, 1'b0, 32'h0}            // R1 reset ends read
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_req = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [AW-1:0] my_addr = 4'h5;
  logic [DW-1:0] reg_val = '0;
  logic [DW-1:0] bus_data;
  logic          bus_drive;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  periph_read_port dut_i (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .bus_addr  (bus_addr),
    .my_addr   (my_addr),
    .reg_val   (reg_val),
    .bus_data  (bus_data),
    .bus_drive (bus_drive)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycle %0d expected below 5000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic step(input logic r, input logic rd, input logic [AW-1:0] a,
                      input logic [DW-1:0] v);
    @(negedge clk);
    rst = r; rd_req = rd; bus_addr = a; reg_val = v;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic ed, input logic [DW-1:0] edata);
    n_run = n_run + 1;
    if (bus_drive !== ed || bus_data !== edata) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual drive=%0b data=%h expected drive=%0b data=%h",
               req, bus_drive, bus_data, ed, edata);
    end
  endtask

  initial begin
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[VW-1], v[VW-2], v[VW-3 -: AW], v[DW+1+DW-1 -: DW]);
      check($sformatf("R%0d-vec%0d", i, i), v[DW], v[DW-1:0]);
    end

    // R3 boundary: top address 0xF as own address
    step(1'b0, 1'b0, 4'h0, 32'h1);
    my_addr = 4'hF;
    step(1'b0, 1'b1, 4'hF, 32'hFFFF_FFFF);
    check("R3 addr F", 1'b1, 32'hFFFF_FFFF);
    step(1'b0, 1'b0, 4'hF, 32'h0);
    check("R9 release after F", 1'b0, 32'h0);

    // R4 boundary: address 0 does not match own address F
    step(1'b0, 1'b1, 4'h0, 32'h1234_5678);
    check("R4 addr 0 vs F", 1'b0, 32'h0);

    // R10: refreshed snapshot at address 0
    step(1'b0, 1'b0, 4'h0, 32'h0);
    my_addr = 4'h0;
    step(1'b0, 1'b1, 4'h0, 32'hA5A5_0001);
    check("R10 fresh snapshot", 1'b1, 32'hA5A5_0001);
    step(1'b0, 1'b1, 4'h0, 32'h0000_0000);
    check("R7 zero input ignored", 1'b1, 32'hA5A5_0001);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule